// File: doc/BRIEF.md
# Call Progress Tone Presence Qualifier

This block sits behind a bank of narrow-band tone filters that watch a telephone line. Each filter gives a raw "energy present" flag. The block turns the flags for five tones into clean detect outputs: 350 Hz, a shared 400/620 Hz channel, 440 Hz, 480 Hz and 425 Hz. Channel logic only moves on a 1 ms timebase tick. A tone must be present for a long qualification window before its detect output rises. Short dropouts are bridged, both while a channel is qualifying and after it has detected, so a detect output does not chatter. A control processor reads the detect outputs and measures their cadence to tell dial tone, ringback, busy and similar signals apart.

A single strobe output shows that at least one detect output is valid. An enable input can force the strobe low. An output-enable input drives a separate enable output that stands for the tri-state control of the five detect pins. A power-down input holds every channel in its cleared state, so qualification restarts from zero when power-down is released. A mode input chooses whether the shared channel listens to the 400 Hz flag or the 620 Hz flag.

Each channel is a five-state machine:
- **CH_IDLE**: no tone.
- **CH_ARM**: counting present ticks.
- **CH_ARM_GAP**: a dropout during qualification. The count is kept.
- **CH_ON**: detected and present.
- **CH_HOLD**: detected, but a dropout is being bridged.

The transitions are:
- **start**: CH_IDLE to CH_ARM, on a present tick.
- **qualify**: CH_ARM or CH_ARM_GAP to CH_ON, on the ON_TICKS-th counted present tick.
- **arm dropout**: CH_ARM to CH_ARM_GAP, on an absent tick.
- **arm resume**: CH_ARM_GAP to CH_ARM, on a present tick.
- **arm abandon**: CH_ARM_GAP to CH_IDLE, on the (GAP_TICKS+1)-th consecutive absent tick.
- **dropout**: CH_ON to CH_HOLD, on an absent tick.
- **bridge**: CH_HOLD to CH_ON, on a present tick.
- **release**: CH_HOLD to CH_IDLE, on the (GAP_TICKS+1)-th consecutive absent tick.
- **clear**: any state to CH_IDLE, while power-down is high.

Top module: `tone_qualifier`

## Requirements
- R1: After reset, `det` is 5'b00000 and `strobe` is 0.
- R2: A channel's `det` bit rises at the clock edge that samples the ON_TICKS-th counted present tick (a tick with the channel's flag high). If a channel has fewer counted present ticks, its `det` bit stays 0.
- R3: Once a `det` bit is high, it stays high through up to GAP_TICKS consecutive absent ticks. It falls on the edge that samples the (GAP_TICKS+1)-th consecutive absent tick. A present tick inside the bridged gap resets the dropout run.
- R4: While a channel is qualifying, an absent run of at most GAP_TICKS ticks keeps the present ticks counted so far, and the absent ticks are not counted. A run of GAP_TICKS+1 absent ticks discards the count.
- R5: Channel state changes only on clock edges where `tick` is high. Changes in `tone_raw` between ticks have no effect.
- R6: The bit order of `tone_raw` is: [0] 350 Hz, [1] 400 Hz, [2] 620 Hz, [3] 440 Hz, [4] 480 Hz, [5] 425 Hz. `det[0]` follows bit 0, `det[2]` follows bit 3, `det[3]` follows bit 4 and `det[4]` follows bit 5. `det[1]` follows bit 2 when `mode` is 1 and bit 1 when `mode` is 0.
- R7: `strobe` is registered. One clock after the detect state changes, `strobe` is 1 if `en` is 1 and at least one `det` bit is 1. Otherwise `strobe` is 0.
- R8: When `en` is 0, `strobe` is 0 from the next clock on, and the detect state is not changed.
- R9: `det_oe` equals `oe`. `oe` does not change `det` or `strobe`.
- R10: While `pd` is 1, all channels are held cleared. `det` and `strobe` are 0 one clock after `pd` rises. After `pd` falls, a channel needs the full ON_TICKS present ticks again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock pulse of the 1 ms timebase |
| tone_raw | input | 6 | Raw presence flags from the filter bank (order in R6) |
| mode | input | 1 | Selects 620 Hz (1) or 400 Hz (0) for `det[1]` |
| en | input | 1 | Strobe enable |
| oe | input | 1 | Detect output enable |
| pd | input | 1 | Power-down; holds all channels cleared |
| det | output | 5 | Qualified detect outputs |
| det_oe | output | 1 | Drive enable for `det` (low means high impedance) |
| strobe | output | 1 | High while any detect output is valid and `en` is high |

## Verification
The assertions assume that `tick` is a single-clock pulse and that `tone_raw`, `mode` and `pd` change only on the inactive clock phase. The bench drives every input on the falling edge, so each tick lasts exactly one clock. The assertions also assume GAP_TICKS is at least 1. The bench uses ON_TICKS = 8 and GAP_TICKS = 3. With these small values it can sweep every run length around both thresholds, on every channel and in both mode settings. It clears all channels with a short power-down pulse between cases.

// File: rtl/tq_pkg.sv
`timescale 1ns/1ps
package tq_pkg;
    typedef enum logic [2:0] {
        CH_IDLE    = 3'd0,
        CH_ARM     = 3'd1,
        CH_ARM_GAP = 3'd2,
        CH_ON      = 3'd3,
        CH_HOLD    = 3'd4
    } ch_state_t;

    localparam int unsigned NUM_CH  = 5;
    localparam int unsigned RAW_W   = 6;
    localparam int unsigned SHARED_CH = 1;
endpackage

// File: rtl/tq_channel.sv
`timescale 1ns/1ps
module tq_channel
    import tq_pkg::*;
#(
    parameter int unsigned ON_TICKS  = 200,
    parameter int unsigned GAP_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic present,
    output logic detected
);
    localparam int unsigned ON_W  = $clog2(ON_TICKS + 1);
    localparam int unsigned GAP_W = $clog2(GAP_TICKS + 1);
    localparam logic [ON_W-1:0]  ON_LAST = ON_W'(ON_TICKS - 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_TICKS);

    ch_state_t        st, st_n;
    logic [ON_W-1:0]  on_cnt, on_n;
    logic [GAP_W-1:0] gap_cnt, gap_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= CH_IDLE;
            on_cnt  <= '0;
            gap_cnt <= '0;
        end else begin
            st      <= st_n;
            on_cnt  <= on_n;
            gap_cnt <= gap_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        on_n  = on_cnt;
        gap_n = gap_cnt;
        if (clear) begin
            st_n  = CH_IDLE;
            on_n  = '0;
            gap_n = '0;
        end else if (tick) begin
            unique case (st)
                CH_IDLE: begin
                    if (present) begin
                        if (ON_TICKS == 1) begin
                            st_n = CH_ON;
                        end else begin
                            st_n = CH_ARM;
                            on_n = ON_W'(1);
                        end
                    end
                end
                CH_ARM, CH_ARM_GAP: begin
                    if (present) begin
                        gap_n = '0;
                        if (on_cnt == ON_LAST) begin
                            st_n = CH_ON;
                            on_n = '0;
                        end else begin
                            st_n = CH_ARM;
                            on_n = on_cnt + 1'b1;
                        end
                    end else if (st == CH_ARM) begin
                        st_n  = CH_ARM_GAP;
                        gap_n = GAP_W'(1);
                    end else if (gap_cnt == GAP_MAX) begin
                        st_n  = CH_IDLE;
                        on_n  = '0;
                        gap_n = '0;
                    end else begin
                        gap_n = gap_cnt + 1'b1;
                    end
                end
                CH_ON: begin
                    if (!present) begin
                        st_n  = CH_HOLD;
                        gap_n = GAP_W'(1);
                    end
                end
                CH_HOLD: begin
                    if (present) begin
                        st_n  = CH_ON;
                        gap_n = '0;
                    end else if (gap_cnt == GAP_MAX) begin
                        st_n  = CH_IDLE;
                        gap_n = '0;
                    end else begin
                        gap_n = gap_cnt + 1'b1;
                    end
                end
                default: begin
                    st_n  = CH_IDLE;
                    on_n  = '0;
                    gap_n = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            CH_ON, CH_HOLD: detected = 1'b1;
            default:        detected = 1'b0;
        endcase
    end

    // R2
    det_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(detected) |-> $past(tick && present && !clear));

    // R2
    on_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_cnt < ON_W'(ON_TICKS));

    // R3
    det_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(detected) |-> $past(clear || (tick && !present)));

    // R5
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(detected));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !detected);
endmodule

// File: rtl/tq_strobe.sv
`timescale 1ns/1ps
module tq_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pd,
    input  logic any_det,
    output logic strobe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= en && !pd && any_det;
    end

    // R8
    strobe_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !strobe);

    // R7
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(any_det));
endmodule

// File: rtl/tone_qualifier.sv
`timescale 1ns/1ps
module tone_qualifier
    import tq_pkg::*;
#(
    parameter int unsigned ON_TICKS  = 200,
    parameter int unsigned GAP_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [RAW_W-1:0] tone_raw,
    input  logic             mode,
    input  logic             en,
    input  logic             oe,
    input  logic             pd,
    output logic [NUM_CH-1:0] det,
    output logic             det_oe,
    output logic             strobe
);
    logic [NUM_CH-1:0] ch_present;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        if (g == 0) begin : g_first
            assign ch_present[g] = tone_raw[0];
        end else if (g == SHARED_CH) begin : g_shared
            assign ch_present[g] = mode ? tone_raw[2] : tone_raw[1];
        end else begin : g_plain
            assign ch_present[g] = tone_raw[g+1];
        end

        tq_channel #(
            .ON_TICKS (ON_TICKS),
            .GAP_TICKS(GAP_TICKS)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (pd),
            .tick    (tick),
            .present (ch_present[g]),
            .detected(det[g])
        );
    end

    tq_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .pd     (pd),
        .any_det(|det),
        .strobe (strobe)
    );

    assign det_oe = oe;

    // R10
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (det == '0) && !strobe);
endmodule

// File: tb/tone_qualifier_tb.sv
`timescale 1ns/1ps
module tone_qualifier_tb;
    localparam int ON  = 8;
    localparam int GAP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [5:0] tone_raw = '0;
    logic       mode = 1'b1, en = 1'b1, oe = 1'b1, pd = 1'b0;
    logic [4:0] det;
    logic       det_oe, strobe;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tone_qualifier #(.ON_TICKS(ON), .GAP_TICKS(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tone_raw(tone_raw),
        .mode(mode), .en(en), .oe(oe), .pd(pd),
        .det(det), .det_oe(det_oe), .strobe(strobe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tk(input logic [5:0] r);
        @(negedge clk); tone_raw = r; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr();
        @(negedge clk); pd = 1'b1; tone_raw = '0;
        repeat (2) @(negedge clk);
        pd = 1'b0;
        @(negedge clk);
    endtask

    // R6 bit order: [0]350 [1]400 [2]620 [3]440 [4]480 [5]425
    function automatic logic [5:0] src(input int ch, input logic m);
        case (ch)
            0: return 6'b000001;
            1: return m ? 6'b000100 : 6'b000010;
            default: return 6'(1) << (ch + 1);
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 det", det, 0);
        chk("R1 strobe", strobe, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R6 / R7: presence length sweep on every channel, both modes
        for (int m = 0; m < 2; m++) begin
            for (int ch = 0; ch < 5; ch++) begin
                for (int n = 1; n <= ON + 1; n++) begin
                    clr();
                    mode = m[0];
                    repeat (n) tk(src(ch, m[0]));
                    chk("R2 R6 det", det, (n >= ON) ? (32'd1 << ch) : 0);
                    chk("R7 strobe", strobe, (n >= ON) ? 1 : 0);
                end
            end
            // R6 the unselected shared flag does not qualify
            clr();
            mode = m[0];
            repeat (ON + 1) tk(m[0] ? 6'b000010 : 6'b000100);
            chk("R6 unselected", det, 0);
        end
        mode = 1'b1;

        // R3 bridging after detection
        for (int g = 0; g <= GAP + 2; g++) begin
            clr();
            repeat (ON) tk(6'b000001);
            repeat (g) tk(6'b000000);
            chk("R3 after gap", det, (g <= GAP) ? 1 : 0);
            tk(6'b000001);
            chk("R3 after resume", det, (g <= GAP) ? 1 : 0);
        end

        // R4 bridging during qualification
        for (int a = 1; a < ON; a++) begin
            for (int g = 1; g <= GAP + 1; g++) begin
                clr();
                repeat (a) tk(6'b001000);
                repeat (g) tk(6'b000000);
                repeat (ON - a) tk(6'b001000);
                chk("R4 gap kept", det, (g <= GAP) ? 32'b00100 : 0);
                if (g > GAP) begin
                    repeat (a) tk(6'b001000);
                    chk("R4 restart", det, 32'b00100);
                end
            end
        end

        // R5 no tick, no change
        clr();
        repeat (ON - 1) tk(6'b100000);
        tone_raw = 6'b100000;
        repeat (20) @(negedge clk);
        chk("R5 no advance", det, 0);
        tk(6'b100000);
        chk("R5 tick advances", det, 32'b10000);
        tone_raw = 6'b000000;
        repeat (40) @(negedge clk);
        chk("R5 no drop", det, 32'b10000);

        // R8 strobe enable
        en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R8 strobe forced", strobe, 0);
        chk("R8 det kept", det, 32'b10000);
        en = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R8 strobe back", strobe, 1);

        // R9 output enable
        oe = 1'b0;
        @(negedge clk);
        chk("R9 det_oe low", det_oe, 0);
        chk("R9 strobe kept", strobe, 1);
        chk("R9 det kept", det, 32'b10000);
        oe = 1'b1;
        @(negedge clk);
        chk("R9 det_oe high", det_oe, 1);

        // R10 power-down
        pd = 1'b1;
        @(negedge clk);
        chk("R10 det cleared", det, 0);
        chk("R10 strobe cleared", strobe, 0);
        repeat (ON + 2) tk(6'b100000);
        chk("R10 held", det, 0);
        pd = 1'b0;
        repeat (ON - 1) tk(6'b100000);
        chk("R10 restart short", det, 0);
        tk(6'b100000);
        chk("R10 restart full", det, 32'b10000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule